// File: doc/BRIEF.md
# Banked Transmit/Receive Byte FIFO with Threshold Status

This block adds a pair of byte queues to a byte-serial bus controller: one holds bytes the host has queued for transmission, the other collects bytes the transfer engine has received. The host reaches the queues through a byte-wide register port. The data register at offset 0x00 is shared. Writing it enqueues a transmit byte and reading it dequeues a received byte. The FIFO control and status registers sit in the window 0x10 to 0x1E, which is shared between two banks. An external bank-select bit chooses which bank decodes that window.

On the bus side the transfer engine takes transmit bytes with a pop strobe and delivers received bytes with a push strobe. Each queue has a programmable threshold with a sticky reached flag and an interrupt enable. A combined event flag marks a drained transmit queue or a filled receive queue. The block also produces three outputs for the protocol engine:
- the data-ready qualification,
- a last-byte hint that tells the engine to answer the next byte with NACK,
- the FIFO part of the interrupt.

While FIFO mode is off, the queues are frozen and data-ready simply follows the engine's own indication.

Top module: `xfer_fifo_bank`

## Requirements
- R1: After reset every FIFO register reads 0x00 in both banks, `irq_o` is low, and `data_ready_o` follows `base_ready_i`.
- R2: Window decode:
  - With `bank_sel_i`=0, offset 0x1D is the mode register; its bit 4 enables FIFO mode.
  - With `bank_sel_i`=1, the registers are 0x10 control/status, 0x12 TX control, 0x1A TX status, 0x1C RX status and 0x1E RX control.
  - Any other offset in the window reads 0x00.
- R3: Writing 1 to bit 6 of 0x10 (bank 1) empties both queues and clears both threshold flags and the event flag. Bit 6 always reads 0. Bit 3 of 0x10 is a read/write interrupt enable for the event flag.
- R4: While FIFO mode is on:
  - a host write to 0x00 appends a byte to the TX queue;
  - each `tx_pop_i` cycle removes the head;
  - `tx_data_o` shows the head, so bytes leave in write order;
  - bits 4:0 of 0x1A give the TX count.
- R5: While FIFO mode is on:
  - each `rx_push_i` cycle appends `rx_data_i` to the RX queue;
  - a host read of 0x00 returns the head and removes it;
  - bits 4:0 of 0x1C give the RX count.
- R6: A push into a full queue (16 bytes) or a pop from an empty queue is ignored and leaves the count and contents unchanged.
- R7: TX threshold flag (bit 6 of 0x1A):
  - The TX threshold is bits 4:0 of 0x12.
  - The flag sets when a pop leaves the TX count at or below the threshold.
  - It clears when the count rises above the threshold, or when 1 is written to bit 6 of 0x1A.
- R8: RX threshold flag (bit 6 of 0x1C):
  - The RX threshold is bits 4:0 of 0x1E.
  - The flag sets when a push leaves the RX count at or above the threshold.
  - It clears when the count falls below the threshold, or when 1 is written to bit 6 of 0x1C.
- R9: Event flag (bit 1 of 0x10):
  - It sets when a pop drains the TX queue to 0, or when a push fills the RX queue to 16.
  - Writing 1 to bit 1 clears it.
- R10: `irq_o` is high exactly when FIFO mode is on and at least one of these holds:
  - the TX flag is set together with bit 6 of 0x12;
  - the RX flag is set together with bit 6 of 0x1E;
  - the event flag is set together with bit 3 of 0x10.
- R11: `data_ready_o` is chosen as follows:
  - With FIFO mode off, it equals `base_ready_i`.
  - With FIFO mode on and `xmit_i`=1, it is high while the TX count is below 16.
  - With FIFO mode on and `xmit_i`=0, it is low while bit 6 of 0x1E is set and the RX count is below 16; otherwise it is high when the RX count is nonzero.
- R12: `rx_last_o` is high when bit 5 of 0x1E is set and the RX count plus one is at least the RX threshold.
- R13: While FIFO mode is off, host data accesses and bus strobes do not change either queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_sel_i | input | 1 | Bank select for the 0x10-0x1E window |
| reg_addr_i | input | 5 | Register offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops RX at 0x00) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| xmit_i | input | 1 | Engine is transmitting (1) or receiving (0) |
| base_ready_i | input | 1 | Engine data-ready used when FIFO mode is off |
| tx_pop_i | input | 1 | Engine takes the TX head byte |
| tx_data_o | output | 8 | TX head byte |
| rx_push_i | input | 1 | Engine delivers a received byte |
| rx_data_i | input | 8 | Received byte |
| data_ready_o | output | 1 | Qualified data-ready |
| rx_last_o | output | 1 | Next received byte is the last one (NACK it) |
| irq_o | output | 1 | FIFO interrupt contribution |

## Verification
A corrupted pointer or count shows up in one of two ways. It appears as a wrong byte at `tx_data_o` or in the 0x00 read data on the very next pop. Otherwise it appears as a wrong count in the status registers as soon as they are read. Flag and event errors show within one cycle on `irq_o` once the matching enable is set. Boundary mistakes around 0 and 16 entries mostly show up on `data_ready_o`, because its value changes on the cycle the queue fills or empties.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;

    localparam int RAW = 5;   // register offset width
    localparam int FW  = 5;   // threshold / count field width

    localparam logic [RAW-1:0] OFS_DATA = 5'h00;
    localparam logic [RAW-1:0] OFS_MODE = 5'h1D;
    localparam logic [RAW-1:0] OFS_CTS  = 5'h10;
    localparam logic [RAW-1:0] OFS_TXC  = 5'h12;
    localparam logic [RAW-1:0] OFS_TXS  = 5'h1A;
    localparam logic [RAW-1:0] OFS_RXS  = 5'h1C;
    localparam logic [RAW-1:0] OFS_RXC  = 5'h1E;

    typedef struct packed {
        logic data;
        logic mode;
        logic cts;
        logic txc;
        logic txs;
        logic rxs;
        logic rxc;
    } reg_sel_t;

    typedef struct packed {
        logic          fifo_en;
        logic          cts_ie;
        logic          evt;
        logic          tx_ie;
        logic [FW-1:0] tx_thr;
        logic          tx_thst;
        logic          rx_ie;
        logic          rx_last;
        logic [FW-1:0] rx_thr;
        logic          rx_thst;
    } ctl_state_t;

endpackage

// File: rtl/xfer_fifo_decode.sv
module xfer_fifo_decode
    import xfer_fifo_pkg::*;
(
    input  logic           bank_sel_i,
    input  logic [RAW-1:0] addr_i,
    output reg_sel_t       sel_o
);

    always_comb begin
        sel_o      = '0;
        sel_o.data = (addr_i == OFS_DATA);
        if (!bank_sel_i) begin
            sel_o.mode = (addr_i == OFS_MODE);
        end else begin
            sel_o.cts = (addr_i == OFS_CTS);
            sel_o.txc = (addr_i == OFS_TXC);
            sel_o.txs = (addr_i == OFS_TXS);
            sel_o.rxs = (addr_i == OFS_RXS);
            sel_o.rxc = (addr_i == OFS_RXC);
        end
    end

endmodule

// File: rtl/xfer_fifo_store.sv
module xfer_fifo_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] head_o,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cnt_nx_o,
    output logic          push_ok_o,
    output logic          pop_ok_o
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } store_t;

    store_t st_d, st_q;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ok_o = push_i && (st_q.cnt != CW'(DEPTH));
    assign pop_ok_o  = pop_i && (st_q.cnt != '0);

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (push_ok_o) begin
                st_d.mem[st_q.wp] = wdata_i;
                st_d.wp           = step(st_q.wp);
            end
            if (pop_ok_o) begin
                st_d.rp = step(st_q.rp);
            end
            case ({push_ok_o, pop_ok_o})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o   = st_q.mem[st_q.rp];
    assign cnt_o    = st_q.cnt;
    assign cnt_nx_o = st_d.cnt;

endmodule

// File: rtl/xfer_fifo_bank.sv
module xfer_fifo_bank
    import xfer_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int XW   = ((CW > FW) ? CW : FW) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bank_sel_i,
    input  logic [RAW-1:0] reg_addr_i,
    input  logic           reg_wr_i,
    input  logic           reg_rd_i,
    input  logic [7:0]     reg_wdata_i,
    output logic [7:0]     reg_rdata_o,
    input  logic           xmit_i,
    input  logic           base_ready_i,
    input  logic           tx_pop_i,
    output logic [7:0]     tx_data_o,
    input  logic           rx_push_i,
    input  logic [7:0]     rx_data_i,
    output logic           data_ready_o,
    output logic           rx_last_o,
    output logic           irq_o
);

    ctl_state_t st_d, st_q;
    reg_sel_t   sel;

    logic          fifo_en_w, rx_ie_w, tx_thst_w, clr_w;
    logic [FW-1:0] tx_thr_w;
    logic          tx_push_w, tx_pop_w, rx_push_w, rx_pop_w;
    logic          tx_push_ok, tx_pop_ok_w, rx_push_ok, rx_pop_ok;
    logic [CW-1:0] tx_cnt_w, rx_cnt_w, tx_cnt_nx, rx_cnt_nx;
    logic [7:0]    rx_head;
    logic [XW-1:0] tx_nx_x, rx_nx_x, tx_thr_x, rx_thr_x;

    xfer_fifo_decode u_dec (
        .bank_sel_i (bank_sel_i),
        .addr_i     (reg_addr_i),
        .sel_o      (sel)
    );

    assign fifo_en_w = st_q.fifo_en;
    assign rx_ie_w   = st_q.rx_ie;
    assign tx_thr_w  = st_q.tx_thr;
    assign tx_thst_w = st_q.tx_thst;
    assign clr_w     = reg_wr_i && sel.cts && reg_wdata_i[6];
    assign tx_push_w = fifo_en_w && reg_wr_i && sel.data;
    assign tx_pop_w  = fifo_en_w && tx_pop_i;
    assign rx_push_w = fifo_en_w && rx_push_i;
    assign rx_pop_w  = fifo_en_w && reg_rd_i && sel.data;

    xfer_fifo_store #(.DEPTH(DEPTH), .DW(8)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr_w),
        .push_i    (tx_push_w),
        .pop_i     (tx_pop_w),
        .wdata_i   (reg_wdata_i),
        .head_o    (tx_data_o),
        .cnt_o     (tx_cnt_w),
        .cnt_nx_o  (tx_cnt_nx),
        .push_ok_o (tx_push_ok),
        .pop_ok_o  (tx_pop_ok_w)
    );

    xfer_fifo_store #(.DEPTH(DEPTH), .DW(8)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr_w),
        .push_i    (rx_push_w),
        .pop_i     (rx_pop_w),
        .wdata_i   (rx_data_i),
        .head_o    (rx_head),
        .cnt_o     (rx_cnt_w),
        .cnt_nx_o  (rx_cnt_nx),
        .push_ok_o (rx_push_ok),
        .pop_ok_o  (rx_pop_ok)
    );

    assign tx_nx_x  = XW'(tx_cnt_nx);
    assign rx_nx_x  = XW'(rx_cnt_nx);
    assign tx_thr_x = XW'(st_q.tx_thr);
    assign rx_thr_x = XW'(st_q.rx_thr);

    always_comb begin
        st_d = st_q;
        if (reg_wr_i) begin
            if (sel.mode) st_d.fifo_en = reg_wdata_i[4];
            if (sel.cts)  st_d.cts_ie  = reg_wdata_i[3];
            if (sel.txc) begin
                st_d.tx_ie  = reg_wdata_i[6];
                st_d.tx_thr = reg_wdata_i[FW-1:0];
            end
            if (sel.rxc) begin
                st_d.rx_ie   = reg_wdata_i[6];
                st_d.rx_last = reg_wdata_i[5];
                st_d.rx_thr  = reg_wdata_i[FW-1:0];
            end
        end

        if (clr_w)                                      st_d.tx_thst = 1'b0;
        else if (tx_pop_ok_w && (tx_nx_x <= tx_thr_x))  st_d.tx_thst = 1'b1;
        else if (tx_nx_x > tx_thr_x)                    st_d.tx_thst = 1'b0;
        else if (reg_wr_i && sel.txs && reg_wdata_i[6]) st_d.tx_thst = 1'b0;

        if (clr_w)                                      st_d.rx_thst = 1'b0;
        else if (rx_push_ok && (rx_nx_x >= rx_thr_x))   st_d.rx_thst = 1'b1;
        else if (rx_nx_x < rx_thr_x)                    st_d.rx_thst = 1'b0;
        else if (reg_wr_i && sel.rxs && reg_wdata_i[6]) st_d.rx_thst = 1'b0;

        if (clr_w)                                      st_d.evt = 1'b0;
        else if (tx_pop_ok_w && (tx_cnt_nx == '0))      st_d.evt = 1'b1;
        else if (rx_push_ok && (rx_cnt_nx == CW'(DEPTH))) st_d.evt = 1'b1;
        else if (reg_wr_i && sel.cts && reg_wdata_i[1]) st_d.evt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata_o = 8'h00;
        if (sel.data)      reg_rdata_o = fifo_en_w ? rx_head : 8'h00;
        else if (sel.mode) reg_rdata_o = {3'b000, st_q.fifo_en, 4'h0};
        else if (sel.cts)  reg_rdata_o = {4'h0, st_q.cts_ie, 1'b0, st_q.evt, 1'b0};
        else if (sel.txc)  reg_rdata_o = {1'b0, st_q.tx_ie, 1'b0, st_q.tx_thr};
        else if (sel.txs)  reg_rdata_o = {1'b0, st_q.tx_thst, 1'b0, FW'(tx_cnt_w)};
        else if (sel.rxs)  reg_rdata_o = {1'b0, st_q.rx_thst, 1'b0, FW'(rx_cnt_w)};
        else if (sel.rxc)  reg_rdata_o = {1'b0, st_q.rx_ie, st_q.rx_last, st_q.rx_thr};
    end

    always_comb begin
        if (!fifo_en_w)                             data_ready_o = base_ready_i;
        else if (xmit_i)                            data_ready_o = (tx_cnt_w != CW'(DEPTH));
        else if (rx_ie_w && (rx_cnt_w != CW'(DEPTH))) data_ready_o = 1'b0;
        else                                        data_ready_o = (rx_cnt_w != '0);
    end

    assign rx_last_o = st_q.rx_last && ((XW'(rx_cnt_w) + 1'b1) >= rx_thr_x);
    assign irq_o     = fifo_en_w && ((st_q.tx_ie && st_q.tx_thst) ||
                                     (st_q.rx_ie && st_q.rx_thst) ||
                                     (st_q.cts_ie && st_q.evt));

endmodule

// File: rtl/xfer_fifo_bank_chk.sv
module xfer_fifo_bank_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          xmit_i,
    input logic          rx_ie,
    input logic          clr,
    input logic          tx_push,
    input logic          tx_pop,
    input logic          tx_pop_ok,
    input logic          rx_push,
    input logic          rx_pop,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic [4:0]    tx_thr,
    input logic          tx_thst,
    input logic          data_ready_o,
    input logic          irq_o
);

    // R11
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && !xmit_i && rx_ie && rx_cnt != CW'(DEPTH)) |-> !data_ready_o);

    // R3
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (tx_cnt == '0 && rx_cnt == '0));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && !tx_pop && !clr && tx_cnt == CW'(DEPTH)) |=> (tx_cnt == CW'(DEPTH)));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !rx_push && !clr && rx_cnt == '0) |=> (rx_cnt == '0));

    // R10
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> !irq_o);

    // R7
    tx_drain_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop_ok && !tx_push && !clr && tx_cnt == CW'(1) && tx_thr == 5'd0) |=> tx_thst);

endmodule

bind xfer_fifo_bank xfer_fifo_bank_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_en      (fifo_en_w),
    .xmit_i       (xmit_i),
    .rx_ie        (rx_ie_w),
    .clr          (clr_w),
    .tx_push      (tx_push_w),
    .tx_pop       (tx_pop_w),
    .tx_pop_ok    (tx_pop_ok_w),
    .rx_push      (rx_push_w),
    .rx_pop       (rx_pop_w),
    .tx_cnt       (tx_cnt_w),
    .rx_cnt       (rx_cnt_w),
    .tx_thr       (tx_thr_w),
    .tx_thst      (tx_thst_w),
    .data_ready_o (data_ready_o),
    .irq_o        (irq_o)
);

// File: tb/xfer_fifo_bank_tb.sv
`timescale 1ns/1ps
module xfer_fifo_bank_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bank_sel_i = 1'b0;
    logic [4:0] reg_addr_i = '0;
    logic       reg_wr_i = 1'b0, reg_rd_i = 1'b0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       xmit_i = 1'b0, base_ready_i = 1'b1;
    logic       tx_pop_i = 1'b0, rx_push_i = 1'b0;
    logic [7:0] tx_data_o, rx_data_i = '0;
    logic       data_ready_o, rx_last_o, irq_o;

    int   n_chk = 0, n_fail = 0;
    bit   tb_on = 1'b0, done = 1'b0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    logic [7:0] v;

    always #10 clk = ~clk;

    xfer_fifo_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bank_sel_i(bank_sel_i), .reg_addr_i(reg_addr_i),
        .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .xmit_i(xmit_i), .base_ready_i(base_ready_i),
        .tx_pop_i(tx_pop_i), .tx_data_o(tx_data_o), .rx_push_i(rx_push_i),
        .rx_data_i(rx_data_i), .data_ready_o(data_ready_o), .rx_last_o(rx_last_o),
        .irq_o(irq_o)
    );

    function automatic void chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endfunction

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
        @(negedge clk); reg_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        reg_addr_i = a; reg_rd_i = 1'b1; #1 d = reg_rdata_o;
        @(negedge clk); reg_rd_i = 1'b0;
    endtask

    task automatic rd_chk(string req, input logic [4:0] a, input logic [7:0] e);
        logic [7:0] t;
        rd(a, t);
        chk(req, t, e);
    endtask

    // driver: host queues a TX byte, scoreboard keeps what should come out
    task automatic host_push(input logic [7:0] b);
        wr(5'h00, b);
        if (tb_on && txq.size() < 16) txq.push_back(b);
    endtask

    task automatic bus_pop();
        tx_pop_i = 1'b1; @(negedge clk); tx_pop_i = 1'b0;
    endtask

    // driver: engine delivers an RX byte
    task automatic bus_push(input logic [7:0] b);
        rx_data_i = b; rx_push_i = 1'b1; @(negedge clk); rx_push_i = 1'b0;
        if (tb_on && rxq.size() < 16) rxq.push_back(b);
    endtask

    // monitor for the RX side: host read of data register
    task automatic host_pop();
        logic [7:0] t;
        rd(5'h00, t);
        if (rxq.size() > 0) chk("R5 rx order", t, rxq.pop_front());
    endtask

    // monitor for the TX side (R4): compare head at each engine pop
    always @(posedge clk) begin
        if (rst_n && tx_pop_i && tb_on && txq.size() > 0)
            chk("R4 tx order", tx_data_o, txq.pop_front());
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", irq_o, 0);
        chk("R1 ready", data_ready_o, 1);
        rd_chk("R1 mode", 5'h1D, 8'h00);
        bank_sel_i = 1'b1;
        rd_chk("R1 cts", 5'h10, 8'h00);
        rd_chk("R1 txc", 5'h12, 8'h00);
        rd_chk("R1 txs", 5'h1A, 8'h00);
        rd_chk("R1 rxs", 5'h1C, 8'h00);
        rd_chk("R1 rxc", 5'h1E, 8'h00);

        // R13 accesses while disabled
        host_push(8'h55);
        bus_push(8'h66);
        tx_pop_i = 1'b1; @(negedge clk); tx_pop_i = 1'b0;

        // R2 bank decode and enable
        bank_sel_i = 1'b0;
        wr(5'h1D, 8'h10); tb_on = 1'b1;
        rd_chk("R2 mode en", 5'h1D, 8'h10);
        bank_sel_i = 1'b1;
        rd_chk("R2 bank1 0x1D", 5'h1D, 8'h00);
        rd_chk("R13 tx untouched", 5'h1A, 8'h00);
        rd_chk("R13 rx untouched", 5'h1C, 8'h00);

        // R3 clear plus enable
        wr(5'h10, 8'h48);
        rd_chk("R3 cts readback", 5'h10, 8'h08);

        // TX path
        xmit_i = 1'b1;
        wr(5'h12, 8'h40);
        host_push(8'hA1); host_push(8'hB2); host_push(8'hC3);
        rd_chk("R4 tx count", 5'h1A, 8'h03);
        chk("R10 irq idle", irq_o, 0);
        repeat (3) bus_pop();
        rd_chk("R7 drained flag", 5'h1A, 8'h40);
        rd_chk("R9 tx empty event", 5'h10, 8'h0A);
        chk("R10 irq on", irq_o, 1);
        wr(5'h10, 8'h0A);
        rd_chk("R9 w1c event", 5'h10, 8'h08);
        chk("R10 irq from tx", irq_o, 1);
        wr(5'h1A, 8'h40);
        rd_chk("R7 w1c flag", 5'h1A, 8'h00);
        chk("R10 irq off", irq_o, 0);

        // R6 overflow / underflow on TX
        for (int i = 0; i < 17; i++) host_push(8'h10 + 8'(i));
        rd_chk("R6 tx full count", 5'h1A, 8'h10);
        chk("R11 tx full ready", data_ready_o, 0);
        repeat (17) bus_pop();
        rd_chk("R6 tx underflow", 5'h1A, 8'h40);
        chk("R11 tx room ready", data_ready_o, 1);
        host_push(8'h77);
        rd_chk("R7 flag leaves", 5'h1A, 8'h01);
        wr(5'h10, 8'h48); txq.delete();
        rd_chk("R3 tx cleared", 5'h1A, 8'h00);
        rd_chk("R3 rx cleared", 5'h1C, 8'h00);
        rd_chk("R3 event cleared", 5'h10, 8'h08);

        // RX path
        xmit_i = 1'b0;
        wr(5'h12, 8'h00);
        wr(5'h1E, 8'h62);
        rd_chk("R2 rxc readback", 5'h1E, 8'h62);
        chk("R11 rx held", data_ready_o, 0);
        chk("R12 last low", rx_last_o, 0);
        bus_push(8'h11);
        chk("R12 last high", rx_last_o, 1);
        bus_push(8'h22);
        rd_chk("R8 rx flag", 5'h1C, 8'h42);
        chk("R10 irq rx", irq_o, 1);
        chk("R11 rx still held", data_ready_o, 0);
        host_pop();
        rd_chk("R8 flag leaves", 5'h1C, 8'h01);
        host_pop();
        host_pop();
        rd_chk("R6 rx underflow", 5'h1C, 8'h00);

        wr(5'h1E, 8'h00);
        chk("R12 last off", rx_last_o, 0);
        chk("R11 rx empty", data_ready_o, 0);
        bus_push(8'h33);
        chk("R11 rx avail", data_ready_o, 1);
        chk("R10 flag without enable", irq_o, 0);
        host_pop();

        for (int i = 0; i < 16; i++) bus_push(8'h80 + 8'(i));
        rd_chk("R9 rx full event", 5'h10, 8'h0A);
        bus_push(8'hFF);
        rd_chk("R6 rx full count", 5'h1C, 8'h50);
        chk("R10 irq event", irq_o, 1);
        chk("R11 rx full ready", data_ready_o, 1);
        repeat (16) host_pop();

        // disable: R10/R11
        bank_sel_i = 1'b0;
        wr(5'h1D, 8'h00); tb_on = 1'b0;
        chk("R10 irq disabled", irq_o, 0);
        base_ready_i = 1'b0; #1;
        chk("R11 base low", data_ready_o, 0);
        base_ready_i = 1'b1; #1;
        chk("R11 base high", data_ready_o, 1);

        finish_run();
    end

endmodule